// File: doc/BRIEF.md
# Class-Latency Register Scoreboard

This block tracks pending register writes for an in-order vector core. The core has two execution pipes, an even pipe and an odd pipe, and a file of 128 registers. On every cycle each pipe offers one slot at its top. The slot carries a valid flag, a flag that says whether the instruction writes a register, the register number and a class code. The class fixes two things: which pipe may take the instruction, and how many cycles its result stays outstanding. The execution pipes never stall. When the issue stage has nothing to send, a bubble enters the pipe instead.

Every accepted slot moves one stage down its pipe on each clock. While a slot's latency has not yet run out, its target register counts as busy. Each stage publishes a report value: -1 for a bubble or for an instruction with no target, the register number while the write is still pending, and 128 once the target has been released. Several query ports let the issue stage ask, in the same cycle, whether a source register is still waiting on a write from either pipe. A flush empties both pipes at once. The latencies are parameters, so a different timing model needs only new parameter values.

Top module: `class_latency_scoreboard`

## Requirements
- R1: After a synchronous reset every stage of both pipes reports -1 and every query reports not busy.
- R2: A slot captured at a clock edge keeps its target busy for exactly L cycles after that edge, where L is set by the class code. The codes and their latencies are: 0 simple fixed-point/logical = 2, 1 element rotate/shift = 4, 2 special byte = 4, 3 single-precision float = 6, 4 integer multiply/conversion = 7, 5 double precision = 7, 8 load/store/hint = 6, 9 shuffle/quadword rotate = 4, 10 branch = 4, 11 channel/special-register move = 6.
- R3: Codes 0 to 6 belong to pipe 0 and codes 8 to 12 belong to pipe 1. A slot that offers a code from the other pipe, or an undefined code (7, 13, 14, 15), enters as a bubble: it reports -1 and marks nothing busy.
- R4: The no-op codes (6 on pipe 0, 12 on pipe 1) have latency 0. A no-op that names a target reports 128 from the first stage on and is never busy.
- R5: Each pipe has MAX_LAT+1 stages (8 by default). The report of pipe p, stage s is the 9-bit two's-complement field at bit offset (p*8+s)*9 of the stage port. It reads 0x1FF (-1) for a bubble, the register number while the write is pending, and 128 after release. A slot leaves the pipe after the last stage.
- R6: The pipes never stall. A captured slot is in stage s exactly s cycles after capture, and a slot can enter either pipe on every cycle.
- R7: When several in-flight slots target the same register, the register stays busy until every one of those pending writes has been released, whichever order they were issued in.
- R8: A flush clears both pipes at the next edge and discards the slots offered in the same cycle. Afterwards every stage reports -1 and nothing is busy.
- R9: A valid slot without a target reports -1 in every stage and never makes a register busy.
- R10: Each of the NQ query ports independently reports, without a clock of delay, whether its register has a pending write in either pipe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clears both pipes at the next edge |
| in_vld | input | 2 | Slot valid, bit p for pipe p |
| in_has_tgt | input | 2 | Slot writes a register, bit p for pipe p |
| in_tgt | input | 14 | Target register, 7 bits per pipe, pipe p at bits [7p+6:7p] |
| in_cls | input | 8 | Class code, 4 bits per pipe, pipe p at bits [4p+3:4p] |
| q_reg | input | 28 | Query register numbers, 7 bits per port |
| q_busy | output | 4 | Busy answer, one bit per query port |
| stage_rep | output | 144 | Stage reports, 9 bits per stage, 8 stages per pipe |

## Verification
The bench aims at the release edge of every class. A design that counts from the wrong cycle would show the register busy one cycle too long or too short, or print 128 in the wrong stage. It offers each pipe the other pipe's codes and the undefined codes. A design that does not filter them would make those registers busy. It issues two writes to one register in both orders: a design that keeps only the newest write would free the register early when a short write follows a long one. It also sends a flush together with fresh slots and sends no-ops with targets, where a weak design would leave stale entries behind or show a no-op as pending.

// File: rtl/scb_pkg.sv
package scb_pkg;

  localparam int CLS_W = 4;
  localparam int NCLS  = 1 << CLS_W;

  // class codes
  localparam logic [CLS_W-1:0] C_FX_SIMPLE = 4'd0;
  localparam logic [CLS_W-1:0] C_FX_ROT    = 4'd1;
  localparam logic [CLS_W-1:0] C_BYTE      = 4'd2;
  localparam logic [CLS_W-1:0] C_FP_SINGLE = 4'd3;
  localparam logic [CLS_W-1:0] C_FX_MUL    = 4'd4;
  localparam logic [CLS_W-1:0] C_FP_DOUBLE = 4'd5;
  localparam logic [CLS_W-1:0] C_NOP_EVEN  = 4'd6;
  localparam logic [CLS_W-1:0] C_LDST      = 4'd8;
  localparam logic [CLS_W-1:0] C_SHUF      = 4'd9;
  localparam logic [CLS_W-1:0] C_BRANCH    = 4'd10;
  localparam logic [CLS_W-1:0] C_CHAN      = 4'd11;
  localparam logic [CLS_W-1:0] C_NOP_ODD   = 4'd12;

  // which codes each pipe accepts
  localparam logic [NCLS-1:0] EVEN_OWN = 16'b0000_0000_0111_1111;
  localparam logic [NCLS-1:0] ODD_OWN  = 16'b0001_1111_0000_0000;

endpackage

// File: rtl/scb_class_decode.sv
module scb_class_decode
  import scb_pkg::*;
#(
  parameter int          PIPE  = 0,
  parameter int          CNT_W = 3,
  parameter int unsigned LAT_TAB [NCLS] = '{default: 0}
) (
  input  logic [CLS_W-1:0] cls_i,
  output logic             own_o,
  output logic [CNT_W-1:0] lat_o
);

  localparam logic [NCLS-1:0] OWN_MASK = (PIPE == 0) ? EVEN_OWN : ODD_OWN;

  always_comb begin
    own_o = OWN_MASK[cls_i];
    lat_o = own_o ? CNT_W'(LAT_TAB[cls_i]) : '0;
  end

endmodule

// File: rtl/scb_exec_pipe.sv
module scb_exec_pipe
  import scb_pkg::*;
#(
  parameter int          PIPE  = 0,
  parameter int          TAG_W = 7,
  parameter int          DEPTH = 8,
  parameter int          CNT_W = 3,
  parameter int unsigned LAT_TAB [NCLS] = '{default: 0}
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic                   in_vld,
  input  logic                   in_has_tgt,
  input  logic [TAG_W-1:0]       in_tgt,
  input  logic [CLS_W-1:0]       in_cls,
  output logic [DEPTH-1:0]       pend_o,
  output logic [DEPTH*TAG_W-1:0] tag_o,
  output logic [DEPTH*(TAG_W+2)-1:0] rep_o
);

  localparam int REP_W = TAG_W + 2;
  localparam logic [REP_W-1:0] REP_NONE = '1;
  localparam logic [REP_W-1:0] REP_DONE = REP_W'(1 << TAG_W);

  logic             own;
  logic [CNT_W-1:0] lat;
  logic             take;

  scb_class_decode #(
    .PIPE    (PIPE),
    .CNT_W   (CNT_W),
    .LAT_TAB (LAT_TAB)
  ) u_dec (
    .cls_i (in_cls),
    .own_o (own),
    .lat_o (lat)
  );

  assign take = in_vld && own && in_has_tgt;

  logic [DEPTH-1:0] has_q;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [CNT_W-1:0] rem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      has_q <= '0;
      for (int s = 0; s < DEPTH; s++) begin
        tag_q[s] <= '0;
        rem_q[s] <= '0;
      end
    end else begin
      has_q[0] <= take;
      tag_q[0] <= in_tgt;
      rem_q[0] <= take ? lat : '0;
      for (int s = 1; s < DEPTH; s++) begin
        has_q[s] <= has_q[s-1];
        tag_q[s] <= tag_q[s-1];
        rem_q[s] <= (rem_q[s-1] == '0) ? '0 : rem_q[s-1] - 1'b1;
      end
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    assign pend_o[s] = has_q[s] && (rem_q[s] != '0);
    assign tag_o[s*TAG_W +: TAG_W] = tag_q[s];
    assign rep_o[s*REP_W +: REP_W] = !has_q[s] ? REP_NONE :
                                     (rem_q[s] != '0) ? {2'b00, tag_q[s]} : REP_DONE;
  end

  // R8: a flush leaves an empty pipe
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (pend_o == '0) && (rep_o == '1));

  // R4: a no-op with a target is never pending in the first stage
  p_nop_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(flush) && $past(in_vld && in_has_tgt &&
      (in_cls == C_NOP_EVEN || in_cls == C_NOP_ODD))) |-> !pend_o[0]);

  // R9: a slot without a target shows as -1 in the first stage
  p_no_tgt_r9: assert property (@(posedge clk) disable iff (rst)
    $past(in_vld && !in_has_tgt) |-> rep_o[REP_W-1:0] == REP_NONE);

  for (genvar s = 1; s < DEPTH; s++) begin : g_chk
    // R2: pending only if it was pending one stage earlier
    p_count_down_r2: assert property (@(posedge clk) disable iff (rst)
      pend_o[s] |-> $past(pend_o[s-1]));
    // R6: a released target stays released as it moves down
    p_released_stays_r6: assert property (@(posedge clk) disable iff (rst)
      (!$past(flush) && $past(rep_o[(s-1)*REP_W +: REP_W]) == REP_DONE)
        |-> rep_o[s*REP_W +: REP_W] == REP_DONE);
  end

endmodule

// File: rtl/scb_busy_lookup.sv
module scb_busy_lookup #(
  parameter int TAG_W = 7,
  parameter int NS    = 16,
  parameter int NQ    = 4
) (
  input  logic [NS-1:0]       pend_i,
  input  logic [NS*TAG_W-1:0] tag_i,
  input  logic [NQ*TAG_W-1:0] q_reg_i,
  output logic [NQ-1:0]       busy_o
);

  always_comb begin
    busy_o = '0;
    for (int q = 0; q < NQ; q++) begin
      for (int e = 0; e < NS; e++) begin
        if (pend_i[e] && (tag_i[e*TAG_W +: TAG_W] == q_reg_i[q*TAG_W +: TAG_W]))
          busy_o[q] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/class_latency_scoreboard.sv
module class_latency_scoreboard
  import scb_pkg::*;
#(
  parameter int TAG_W          = 7,
  parameter int NQ             = 4,
  parameter int MAX_LAT        = 7,
  parameter int LAT_FX_SIMPLE  = 2,
  parameter int LAT_FX_ROT     = 4,
  parameter int LAT_BYTE       = 4,
  parameter int LAT_FP_SINGLE  = 6,
  parameter int LAT_FX_MUL     = 7,
  parameter int LAT_FP_DOUBLE  = 7,
  parameter int LAT_NOP_EVEN   = 0,
  parameter int LAT_LDST       = 6,
  parameter int LAT_SHUF       = 4,
  parameter int LAT_BRANCH     = 4,
  parameter int LAT_CHAN       = 6,
  parameter int LAT_NOP_ODD    = 0,
  localparam int NPIPE         = 2,
  localparam int DEPTH         = MAX_LAT + 1,
  localparam int REP_W         = TAG_W + 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic [NPIPE-1:0]             in_vld,
  input  logic [NPIPE-1:0]             in_has_tgt,
  input  logic [NPIPE*TAG_W-1:0]       in_tgt,
  input  logic [NPIPE*CLS_W-1:0]       in_cls,
  input  logic [NQ*TAG_W-1:0]          q_reg,
  output logic [NQ-1:0]                q_busy,
  output logic [NPIPE*DEPTH*REP_W-1:0] stage_rep
);

  localparam int CNT_W = $clog2(MAX_LAT + 1);
  localparam int NS    = NPIPE * DEPTH;
  localparam int unsigned LAT_TAB [NCLS] = '{
    LAT_FX_SIMPLE, LAT_FX_ROT, LAT_BYTE, LAT_FP_SINGLE,
    LAT_FX_MUL, LAT_FP_DOUBLE, LAT_NOP_EVEN, 0,
    LAT_LDST, LAT_SHUF, LAT_BRANCH, LAT_CHAN,
    LAT_NOP_ODD, 0, 0, 0};

  logic [NS-1:0]       all_pend;
  logic [NS*TAG_W-1:0] all_tag;

  for (genvar p = 0; p < NPIPE; p++) begin : g_pipe
    scb_exec_pipe #(
      .PIPE    (p),
      .TAG_W   (TAG_W),
      .DEPTH   (DEPTH),
      .CNT_W   (CNT_W),
      .LAT_TAB (LAT_TAB)
    ) u_pipe (
      .clk        (clk),
      .rst        (rst),
      .flush      (flush),
      .in_vld     (in_vld[p]),
      .in_has_tgt (in_has_tgt[p]),
      .in_tgt     (in_tgt[p*TAG_W +: TAG_W]),
      .in_cls     (in_cls[p*CLS_W +: CLS_W]),
      .pend_o     (all_pend[p*DEPTH +: DEPTH]),
      .tag_o      (all_tag[p*DEPTH*TAG_W +: DEPTH*TAG_W]),
      .rep_o      (stage_rep[p*DEPTH*REP_W +: DEPTH*REP_W])
    );
  end

  scb_busy_lookup #(
    .TAG_W (TAG_W),
    .NS    (NS),
    .NQ    (NQ)
  ) u_busy (
    .pend_i  (all_pend),
    .tag_i   (all_tag),
    .q_reg_i (q_reg),
    .busy_o  (q_busy)
  );

  // R1: nothing is busy in the cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (q_busy == '0) && (stage_rep == '1));

  // R3: a code foreign to pipe 0 never makes its first stage pending
  p_foreign_cls_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(flush) && $past(in_vld[0] && in_cls[CLS_W-1])) |-> !all_pend[0]);

endmodule

// File: tb/class_latency_scoreboard_test.sv
module class_latency_scoreboard_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int REP_W = 9;
  localparam int NQ = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         flush = 1'b0;
  logic [1:0]   in_vld = '0;
  logic [1:0]   in_has_tgt = '0;
  logic [13:0]  in_tgt = '0;
  logic [7:0]   in_cls = '0;
  logic [27:0]  q_reg = '0;
  logic [3:0]   q_busy;
  logic [143:0] stage_rep;

  class_latency_scoreboard uut (
    .clk (clk), .rst (rst), .flush (flush),
    .in_vld (in_vld), .in_has_tgt (in_has_tgt),
    .in_tgt (in_tgt), .in_cls (in_cls),
    .q_reg (q_reg), .q_busy (q_busy), .stage_rep (stage_rep)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { int p; int tgt; bit has; int lat; int ent; } item_t;
  item_t fly[$];

  int    cyc = 0;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    mon_en = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    qv [NQ];

  always @(posedge clk) cyc <= cyc + 1;

  // latency table from the requirements (R2, R3, R4); -1 = not accepted
  function automatic int exp_lat(int p, int c);
    if (p == 0) begin
      case (c)
        0: return 2; 1: return 4; 2: return 4; 3: return 6;
        4: return 7; 5: return 7; 6: return 0;
        default: return -1;
      endcase
    end else begin
      case (c)
        8: return 6; 9: return 4; 10: return 4; 11: return 6; 12: return 0;
        default: return -1;
      endcase
    end
  endfunction

  function automatic logic [REP_W-1:0] enc(int v);
    return (v < 0) ? '1 : REP_W'(v);
  endfunction

  // monitor: compares the design against the in-flight queue
  always @(negedge clk) begin
    if (mon_en && !rst && !done) begin
      for (int p = 0; p < 2; p++) begin
        logic [DEPTH*REP_W-1:0] exp_v;
        for (int s = 0; s < DEPTH; s++) begin
          int v;
          v = -1;
          foreach (fly[i])
            if (fly[i].p == p && cyc - fly[i].ent == s)
              v = !fly[i].has ? -1 : (s < fly[i].lat ? fly[i].tgt : 128);
          exp_v[s*REP_W +: REP_W] = enc(v);
        end
        n_chk++;
        if (stage_rep[p*DEPTH*REP_W +: DEPTH*REP_W] !== exp_v) begin
          n_bad++;
          $display("FAIL %s pipe %0d stages: actual %h expected %h", cur_req, p,
                   stage_rep[p*DEPTH*REP_W +: DEPTH*REP_W], exp_v);
        end
      end
      for (int q = 0; q < NQ; q++) begin
        bit eb;
        eb = 1'b0;
        foreach (fly[i])
          if (fly[i].has && fly[i].tgt == qv[q] && cyc - fly[i].ent < fly[i].lat)
            eb = 1'b1;
        n_chk++;
        if (q_busy[q] !== eb) begin
          n_bad++;
          $display("FAIL %s query %0d reg %0d: actual %b expected %b", cur_req, q,
                   qv[q], q_busy[q], eb);
        end
      end
    end
  end

  task automatic setq(int a, int b, int c, int d);
    qv[0] = a; qv[1] = b; qv[2] = c; qv[3] = d;
    for (int q = 0; q < NQ; q++) q_reg[q*7 +: 7] = 7'(qv[q]);
  endtask

  // driver: offers one slot per pipe, then records the expectation
  task automatic step(bit v0, bit h0, int t0, int c0,
                      bit v1, bit h1, int t1, int c1, bit fl);
    @(negedge clk);
    in_vld = {v1, v0};
    in_has_tgt = {h1, h0};
    in_tgt = {7'(t1), 7'(t0)};
    in_cls = {4'(c1), 4'(c0)};
    flush = fl;
    @(posedge clk);
    #1;
    if (fl) fly.delete();
    else begin
      if (v0 && exp_lat(0, c0) >= 0) fly.push_back('{0, t0, h0, exp_lat(0, c0), cyc});
      if (v1 && exp_lat(1, c1) >= 0) fly.push_back('{1, t1, h1, exp_lat(1, c1), cyc});
    end
    for (int i = fly.size() - 1; i >= 0; i--)
      if (cyc - fly[i].ent >= DEPTH) fly.delete(i);
    in_vld = '0; flush = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    setq(0, 1, 2, 3);
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    mon_en = 1'b1;
    // R1: idle after reset
    cur_req = "R1";
    idle(2);

    // R2: every class, both pipes, release edges
    cur_req = "R2";
    setq(5, 6, 10, 11);
    step(1, 1, 5, 0, 1, 1, 6, 8, 0);
    idle(9);
    setq(10, 11, 12, 13);
    step(1, 1, 10, 1, 1, 1, 11, 9, 0);
    step(1, 1, 12, 2, 1, 1, 13, 10, 0);
    setq(14, 15, 16, 17);
    step(1, 1, 14, 3, 1, 1, 15, 11, 0);
    step(1, 1, 16, 4, 0, 0, 0, 0, 0);
    setq(16, 17, 14, 15);
    step(1, 1, 17, 5, 0, 0, 0, 0, 0);
    idle(9);

    // R3: foreign and undefined codes become bubbles
    cur_req = "R3";
    setq(20, 21, 22, 23);
    step(1, 1, 20, 8, 1, 1, 21, 0, 0);
    step(1, 1, 22, 7, 1, 1, 23, 15, 0);
    step(1, 1, 22, 12, 1, 1, 23, 6, 0);
    idle(3);

    // R4: no-ops with targets
    cur_req = "R4";
    setq(30, 31, 0, 0);
    step(1, 1, 30, 6, 1, 1, 31, 12, 0);
    idle(3);

    // R5: a long write walks all stages and leaves
    cur_req = "R5";
    setq(127, 0, 1, 2);
    step(1, 1, 127, 5, 1, 1, 0, 11, 0);
    idle(9);

    // R6: back-to-back entries every cycle
    cur_req = "R6";
    setq(50, 60, 53, 63);
    for (int i = 0; i < 6; i++) step(1, 1, 50 + i, i % 6, 1, 1, 60 + i, 8 + (i % 4), 0);
    idle(9);

    // R7: same register twice, short then long, then long then short
    cur_req = "R7";
    setq(40, 41, 0, 0);
    step(1, 1, 40, 0, 1, 1, 41, 8, 0);
    step(1, 1, 40, 4, 1, 1, 41, 9, 0);
    idle(9);
    step(1, 1, 40, 5, 1, 1, 41, 11, 0);
    step(1, 1, 40, 0, 1, 1, 41, 10, 0);
    idle(9);

    // R8: flush with fresh slots in the same cycle
    cur_req = "R8";
    setq(70, 71, 72, 73);
    step(1, 1, 70, 5, 1, 1, 71, 8, 0);
    step(1, 1, 72, 3, 1, 1, 73, 11, 0);
    step(1, 1, 70, 4, 1, 1, 71, 9, 1);
    idle(3);

    // R9: valid slots without targets
    cur_req = "R9";
    setq(80, 81, 0, 0);
    step(1, 0, 80, 5, 1, 0, 81, 8, 0);
    idle(9);

    // R10: four independent queries across both pipes
    cur_req = "R10";
    setq(90, 91, 92, 93);
    step(1, 1, 90, 3, 1, 1, 91, 8, 0);
    step(1, 1, 92, 0, 1, 1, 93, 9, 0);
    setq(93, 92, 91, 94);
    idle(8);

    finish_run();
  end

endmodule